// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs every control-flow change of an 8-bit processor that passes through the stack or a vector table: the start-up fetch after reset, entry into a non-maskable or a maskable interrupt, a software break, the return from an interrupt handler and the pull of the status byte alone. The instruction decoder tells it when an instruction has finished and which of the break, return or status-pull operations it asked for. The block samples the interrupt pins at that point and then drives one byte access per cycle on a memory port. When it is done it presents the new program counter, stack pointer and status byte for one cycle.

The stack is descending and sits in page one, at address 0x0100 plus the 8-bit stack pointer. Vectors are stored little-endian: the non-maskable vector at 0xFFFA, the reset vector at 0xFFFC, and the shared maskable/break vector at 0xFFFE. Status bits used here are I (bit 2), B (bit 4) and the always-one bit U (bit 5). Memory read data is taken in the same cycle as the address.

Top module: `intr_sequencer`

## Requirements
- R1: After rst_ni is released the block reads 0xFFFC, then 0xFFFD, in consecutive busy cycles. It then loads pc_o with {data@0xFFFD, data@0xFFFC}, s_o with s_i minus 3 (mod 256) and p_o with p_i | 0x30.
- R2: A sequence starts only at a clock edge where step_i is high while the block is idle. Without step_i, held requests cause no memory access and no busy.
- R3: When several requests coexist at a step, the order is break, return, status pull, non-maskable, maskable. The others wait for a later step.
- R4: A high nmi_i is serviced once. It is serviced again only after nmi_i has been seen low at some clock edge.
- R5: A high irq_i starts a maskable entry only when p_i bit 2 (I) is 0. With I set it has no effect.
- R6: Hardware entry writes PC[15:8] at 0x0100+S, PC[7:0] at 0x0100+(S-1), and (p_i & ~0x10) | 0x20 at 0x0100+(S-2), all mod 256 in the low byte. It then reads the vector low and high bytes (0xFFFA for non-maskable, 0xFFFE for maskable) and ends with s_o = S-3, p_o = p_i | 0x04 and pc_o = vector.
- R7: A break pushes pc_i+1 (high byte first) and p_i | 0x30 with the same addresses, reads 0xFFFE/0xFFFF, and ends with p_o = p_i | 0x04.
- R8: A return reads 0x0100+(S+1) as status, then S+2 as PC low, then S+3 as PC high. It ends with p_o = status | 0x30, pc_o = {high, low} and s_o = S+3.
- R9: A status pull reads 0x0100+(S+1) only, and ends with p_o = data | 0x30, s_o = S+1 and pc_o = pc_i as sampled at the step.
- R10: busy_o is high from the first access cycle to the last, with exactly one memory access per busy cycle and none while idle. step_i and requests during busy are ignored.
- R11: done_o pulses for one cycle right after the last access; pc_o, s_o and p_o carry the result in that cycle, and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; release starts the reset fetch |
| step_i | input | 1 | Instruction-boundary strobe |
| brk_i | input | 1 | Software break requested by the current instruction |
| rti_i | input | 1 | Return from interrupt requested |
| plp_i | input | 1 | Status pull requested |
| nmi_i | input | 1 | Non-maskable interrupt pin level |
| irq_i | input | 1 | Maskable interrupt pin level |
| pc_i | input | 16 | Current program counter |
| s_i | input | 8 | Current stack pointer |
| p_i | input | 8 | Current status byte |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data for the current address |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle result strobe |
| pc_o | output | 16 | New program counter |
| s_o | output | 8 | New stack pointer |
| p_o | output | 8 | New status byte |

## Verification
The hardest case to reach is the non-maskable line held high across several instruction boundaries while other requests compete for the same step. Only the hidden arming state decides whether it is taken. The stimulus raises break, non-maskable and maskable requests together, then steps repeatedly with the non-maskable line still high, then drops it for a single cycle before raising it again. The per-cycle model predicts each access, so a lost or repeated service shows on the bus at once. Stack-page wrap is reached by breaking with S = 0x01 and PC = 0xFFFF and then returning from S = 0xFE.

// File: rtl/isr_seq_pkg.sv
`timescale 1ns/1ps
package isr_seq_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  localparam int SB_I = 2;
  localparam int SB_B = 4;
  localparam int SB_U = 5;
  localparam logic [DW-1:0] BIT_I = DW'(1 << SB_I);
  localparam logic [DW-1:0] BIT_B = DW'(1 << SB_B);
  localparam logic [DW-1:0] BIT_U = DW'(1 << SB_U);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P,
    ST_VEC_L, ST_VEC_H, ST_PULL_P, ST_PULL_L, ST_PULL_H
  } seq_st_e;

  typedef enum logic [2:0] {
    K_NONE, K_NMI, K_IRQ, K_BRK, K_RTI, K_PLP
  } kind_e;
endpackage

// File: rtl/isr_arbiter.sv
`timescale 1ns/1ps
module isr_arbiter
  import isr_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  logic  idle_i,
  input  logic  brk_i,
  input  logic  rti_i,
  input  logic  plp_i,
  input  logic  nmi_i,
  input  logic  irq_i,
  input  logic  irq_mask_i,
  output logic  start_o,
  output kind_e kind_o
);
  logic armed_q;

  // instruction-driven requests first, then pins
  always_comb begin
    if (brk_i)                    kind_o = K_BRK;
    else if (rti_i)               kind_o = K_RTI;
    else if (plp_i)               kind_o = K_PLP;
    else if (nmi_i && armed_q)    kind_o = K_NMI;
    else if (irq_i && !irq_mask_i) kind_o = K_IRQ;
    else                          kind_o = K_NONE;
  end

  assign start_o = step_i && idle_i && (kind_o != K_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          armed_q <= 1'b1;
    else if (!nmi_i)                      armed_q <= 1'b1;
    else if (start_o && kind_o == K_NMI)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/isr_stack.sv
`timescale 1ns/1ps
module isr_stack
  import isr_seq_pkg::*;
#(
  parameter logic [DW-1:0] PAGE = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          push_i,
  input  logic          pull_i,
  output logic [DW-1:0] sp_nxt_o,
  output logic [AW-1:0] push_addr_o,
  output logic [AW-1:0] pull_addr_o
);
  logic [DW-1:0] sp_q;

  always_comb begin
    sp_nxt_o = sp_q;
    if (load_i)      sp_nxt_o = load_val_i;
    else if (push_i) sp_nxt_o = sp_q - DW'(1);
    else if (pull_i) sp_nxt_o = sp_q + DW'(1);
  end

  assign push_addr_o = {PAGE, sp_q};
  assign pull_addr_o = {PAGE, sp_q + DW'(1)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else         sp_q <= sp_nxt_o;
  end
endmodule

// File: rtl/intr_sequencer.sv
`timescale 1ns/1ps
module intr_sequencer
  import isr_seq_pkg::*;
#(
  parameter logic [AW-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          brk_i,
  input  logic          rti_i,
  input  logic          plp_i,
  input  logic          nmi_i,
  input  logic          irq_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] p_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] s_o,
  output logic [DW-1:0] p_o
);
  seq_st_e       st_q;
  kind_e         kind, kind_q;
  logic          start, rst_seq_q;
  logic [AW-1:0] vec_q, push_pc_q, cap_pc_q;
  logic [DW-1:0] push_p_q, p_new_q, lo_q;
  logic          stk_load, stk_push, stk_pull;
  logic [DW-1:0] stk_load_val, sp_nxt;
  logic [AW-1:0] push_addr, pull_addr;

  isr_arbiter u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_i),
    .idle_i     (st_q == ST_IDLE),
    .brk_i      (brk_i),
    .rti_i      (rti_i),
    .plp_i      (plp_i),
    .nmi_i      (nmi_i),
    .irq_i      (irq_i),
    .irq_mask_i (p_i[SB_I]),
    .start_o    (start),
    .kind_o     (kind)
  );

  assign stk_load     = start || (st_q == ST_VEC_L && rst_seq_q);
  assign stk_load_val = start ? s_i : s_i - DW'(3);
  assign stk_push     = st_q inside {ST_PUSH_H, ST_PUSH_L, ST_PUSH_P};
  assign stk_pull     = st_q inside {ST_PULL_P, ST_PULL_L, ST_PULL_H};

  isr_stack #(.PAGE(STACK_PAGE)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (stk_load),
    .load_val_i  (stk_load_val),
    .push_i      (stk_push),
    .pull_i      (stk_pull),
    .sp_nxt_o    (sp_nxt),
    .push_addr_o (push_addr),
    .pull_addr_o (pull_addr)
  );

  assign mem_req_o = (st_q != ST_IDLE);
  assign busy_o    = (st_q != ST_IDLE);

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (st_q)
      ST_PUSH_H: begin mem_we_o = 1'b1; mem_addr_o = push_addr; mem_wdata_o = push_pc_q[AW-1:DW]; end
      ST_PUSH_L: begin mem_we_o = 1'b1; mem_addr_o = push_addr; mem_wdata_o = push_pc_q[DW-1:0];  end
      ST_PUSH_P: begin mem_we_o = 1'b1; mem_addr_o = push_addr; mem_wdata_o = push_p_q;           end
      ST_VEC_L:  mem_addr_o = vec_q;
      ST_VEC_H:  mem_addr_o = vec_q + AW'(1);
      ST_PULL_P, ST_PULL_L, ST_PULL_H: mem_addr_o = pull_addr;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_VEC_L;   // reset fetch starts on release
      rst_seq_q <= 1'b1;
      vec_q     <= VEC_RST;
      kind_q    <= K_NONE;
      push_pc_q <= '0;
      cap_pc_q  <= '0;
      push_p_q  <= '0;
      p_new_q   <= '0;
      lo_q      <= '0;
      done_o    <= 1'b0;
      pc_o      <= '0;
      s_o       <= '0;
      p_o       <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          kind_q   <= kind;
          cap_pc_q <= pc_i;
          p_new_q  <= p_i | BIT_I;
          case (kind)
            K_BRK: begin
              push_pc_q <= pc_i + AW'(1);
              push_p_q  <= p_i | BIT_B | BIT_U;
              vec_q     <= VEC_IRQ;
              st_q      <= ST_PUSH_H;
            end
            K_NMI, K_IRQ: begin
              push_pc_q <= pc_i;
              push_p_q  <= (p_i & ~BIT_B) | BIT_U;
              vec_q     <= (kind == K_NMI) ? VEC_NMI : VEC_IRQ;
              st_q      <= ST_PUSH_H;
            end
            default: st_q <= ST_PULL_P;
          endcase
        end
        ST_PUSH_H: st_q <= ST_PUSH_L;
        ST_PUSH_L: st_q <= ST_PUSH_P;
        ST_PUSH_P: st_q <= ST_VEC_L;
        ST_VEC_L: begin
          lo_q <= mem_rdata_i;
          if (rst_seq_q) p_new_q <= p_i | BIT_B | BIT_U;
          st_q <= ST_VEC_H;
        end
        ST_VEC_H: begin
          pc_o      <= {mem_rdata_i, lo_q};
          s_o       <= sp_nxt;
          p_o       <= p_new_q;
          done_o    <= 1'b1;
          rst_seq_q <= 1'b0;
          st_q      <= ST_IDLE;
        end
        ST_PULL_P: begin
          if (kind_q == K_PLP) begin
            pc_o   <= cap_pc_q;
            s_o    <= sp_nxt;
            p_o    <= mem_rdata_i | BIT_B | BIT_U;
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            p_new_q <= mem_rdata_i | BIT_B | BIT_U;
            st_q    <= ST_PULL_L;
          end
        end
        ST_PULL_L: begin
          lo_q <= mem_rdata_i;
          st_q <= ST_PULL_H;
        end
        ST_PULL_H: begin
          pc_o   <= {mem_rdata_i, lo_q};
          s_o    <= sp_nxt;
          p_o    <= p_new_q;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_sequencer_chk.sv
`timescale 1ns/1ps
module intr_sequencer_chk #(
  parameter logic [7:0] PAGE = 8'h01
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        step_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [15:0] mem_addr_o
);
  logic rd_stk, rd_vec_lo;
  assign rd_stk    = mem_req_o && !mem_we_o && (mem_addr_o[15:8] == PAGE);
  assign rd_vec_lo = mem_req_o && !mem_we_o && (mem_addr_o[15:8] == 8'hFF) && !mem_addr_o[0];

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_end_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_start_on_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(step_i));
  p_push_descend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o[7:0] == 8'($past(mem_addr_o[7:0]) - 8'd1));
  p_pull_ascend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stk && $past(rd_stk)) |-> mem_addr_o[7:0] == 8'($past(mem_addr_o[7:0]) + 8'd1));
  p_vec_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vec_lo |=> (mem_req_o && mem_addr_o == 16'($past(mem_addr_o) + 16'd1)));
endmodule

bind intr_sequencer intr_sequencer_chk #(.PAGE(STACK_PAGE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/intr_sequencer_bench.sv
`timescale 1ns/1ps
module intr_sequencer_bench;
  typedef logic [24:0] op_t;   // {we, addr[15:0], data[7:0]}

  logic        clk = 1'b0, rst_n = 1'b1;
  logic        step = 0, brk = 0, rti = 0, plp = 0, nmi = 0, irq = 0;
  logic [15:0] pc_in = 16'h1234;
  logic [7:0]  s_in = 8'hFD, p_in = 8'h00;
  logic        mem_req, mem_we, busy, done;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, mem_rdata, s_out, p_out;

  int checks = 0, failures = 0;
  string phase_tag = "R2";

  always #2.5 clk = ~clk;

  intr_sequencer u_intr_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .brk_i(brk), .rti_i(rti),
    .plp_i(plp), .nmi_i(nmi), .irq_i(irq), .pc_i(pc_in), .s_i(s_in), .p_i(p_in),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .done_o(done), .pc_o(pc_out), .s_o(s_out), .p_o(p_out)
  );

  // memory: written bytes, else a fixed address hash
  logic [7:0] wmem [int];
  function automatic logic [7:0] rd(input logic [15:0] a);
    if (wmem.exists(int'(a))) return wmem[int'(a)];
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  always @(mem_addr) mem_rdata = rd(mem_addr);
  always @(posedge clk) if (rst_n && mem_req && mem_we) wmem[int'(mem_addr)] = mem_wdata;

  // reference model
  op_t op_q[$];
  logic [15:0] r_pc, e_pc;
  logic [7:0]  r_s, r_p, e_s, e_p;
  string r_tag = "R1", e_tag = "R1";
  logic exp_done = 0, armed = 1;

  function automatic op_t mk(input logic we, input logic [15:0] a, input logic [7:0] d);
    return {we, a, d};
  endfunction

  task automatic plan_push(input logic [15:0] pcv, input logic [7:0] pb,
                           input logic [15:0] vec, input logic [7:0] s);
    op_q.push_back(mk(1'b1, {8'h01, s}, pcv[15:8]));
    op_q.push_back(mk(1'b1, {8'h01, 8'(s - 8'd1)}, pcv[7:0]));
    op_q.push_back(mk(1'b1, {8'h01, 8'(s - 8'd2)}, pb));
    op_q.push_back(mk(1'b0, vec, 8'h00));
    op_q.push_back(mk(1'b0, 16'(vec + 16'd1), 8'h00));
    r_pc = {rd(16'(vec + 16'd1)), rd(vec)};
    r_s  = 8'(s - 8'd3);
    r_p  = p_in | 8'h04;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q.delete();
      op_q.push_back(mk(1'b0, 16'hFFFC, 8'h00));
      op_q.push_back(mk(1'b0, 16'hFFFD, 8'h00));
      r_pc = {rd(16'hFFFD), rd(16'hFFFC)};
      r_s = 8'(s_in - 8'd3);
      r_p = p_in | 8'h30;
      r_tag = "R1";
      exp_done = 0;
      armed = 1;
    end else begin
      exp_done = 0;
      if (op_q.size() != 0) begin
        void'(op_q.pop_front());
        if (op_q.size() == 0) begin
          exp_done = 1; e_pc = r_pc; e_s = r_s; e_p = r_p; e_tag = r_tag;
        end
      end else if (step) begin
        int nreq;
        nreq = int'(brk) + int'(rti) + int'(plp) + int'(nmi && armed) + int'(irq && !p_in[2]);
        if (brk) begin
          r_tag = "R7";
          plan_push(16'(pc_in + 16'd1), p_in | 8'h30, 16'hFFFE, s_in);
        end else if (rti) begin
          r_tag = "R8";
          op_q.push_back(mk(1'b0, {8'h01, 8'(s_in + 8'd1)}, 8'h00));
          op_q.push_back(mk(1'b0, {8'h01, 8'(s_in + 8'd2)}, 8'h00));
          op_q.push_back(mk(1'b0, {8'h01, 8'(s_in + 8'd3)}, 8'h00));
          r_p  = rd({8'h01, 8'(s_in + 8'd1)}) | 8'h30;
          r_pc = {rd({8'h01, 8'(s_in + 8'd3)}), rd({8'h01, 8'(s_in + 8'd2)})};
          r_s  = 8'(s_in + 8'd3);
        end else if (plp) begin
          r_tag = "R9";
          op_q.push_back(mk(1'b0, {8'h01, 8'(s_in + 8'd1)}, 8'h00));
          r_p  = rd({8'h01, 8'(s_in + 8'd1)}) | 8'h30;
          r_pc = pc_in;
          r_s  = 8'(s_in + 8'd1);
        end else if (nmi && armed) begin
          r_tag = "R4";
          armed = 0;
          plan_push(pc_in, (p_in & 8'hEF) | 8'h20, 16'hFFFA, s_in);
        end else if (irq && !p_in[2]) begin
          r_tag = "R5";
          plan_push(pc_in, (p_in & 8'hEF) | 8'h20, 16'hFFFE, s_in);
        end
        if (nreq > 1) r_tag = "R3";
      end
      if (!nmi) armed = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare against model away from the active edge
  always @(negedge clk) begin
    if (op_q.size() != 0) begin
      op_t h;
      h = op_q[0];
      chk(busy === 1'b1, "R10", "busy", 16'(busy), 16'd1);
      chk(mem_req === 1'b1 && mem_we === h[24], r_tag, "req/we",
          {14'd0, mem_req, mem_we}, {14'd0, 1'b1, h[24]});
      chk(mem_addr === h[23:8], r_tag, "addr", mem_addr, h[23:8]);
      if (h[24]) chk(mem_wdata === h[7:0], r_tag, "wdata", 16'(mem_wdata), 16'(h[7:0]));
    end else begin
      chk(busy === 1'b0 && mem_req === 1'b0, phase_tag, "idle bus",
          {14'd0, busy, mem_req}, 16'd0);
    end
    chk(done === exp_done, "R11", "done", 16'(done), 16'(exp_done));
    if (exp_done) begin
      chk(pc_out === e_pc, e_tag, "pc_o", pc_out, e_pc);
      chk(s_out === e_s, e_tag, "s_o", 16'(s_out), 16'(e_s));
      chk(p_out === e_p, e_tag, "p_o", 16'(p_out), 16'(e_p));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step1();
    @(negedge clk); step = 1;
    @(negedge clk); step = 0; brk = 0; rti = 0; plp = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    #1 rst_n = 0;                       // R1 reset state checked while held
    idle(3);
    rst_n = 1;
    idle(4);
    phase_tag = "R2"; brk = 1; idle(4); brk = 0;   // R2 no step, no start
    phase_tag = "R5"; irq = 1; step1(); idle(7);   // R5 taken, I clear
    p_in = 8'h04; step1(); idle(3);                // R5 masked
    irq = 0; p_in = 8'h00;
    phase_tag = "R4"; pc_in = 16'h4321; s_in = 8'hF0;
    nmi = 1; step1(); idle(7);
    step1(); idle(3);                              // R4 still high: no service
    nmi = 0; idle(1);
    nmi = 1; step1(); idle(7);                     // R4 re-armed
    nmi = 0; idle(1);
    phase_tag = "R3"; nmi = 1; irq = 1; brk = 1; p_in = 8'hC3;
    step1(); idle(7);                              // R3 break wins
    step1(); idle(7);                              // then NMI
    step1(); idle(7);                              // then IRQ
    nmi = 0; irq = 0;
    phase_tag = "R10";                             // R10 requests during busy ignored
    @(negedge clk); step = 1; brk = 1;
    @(negedge clk); brk = 0; rti = 1;
    idle(3); step = 0; rti = 0; idle(5);
    phase_tag = "R6"; p_in = 8'h5A; s_in = 8'h01; pc_in = 16'hFFFF;
    brk = 1; step1(); idle(7);                     // R6/R7 wrap of stack page
    s_in = 8'hFE; p_in = 8'h00;
    rti = 1; step1(); idle(5);                     // R8 pull across wrap
    s_in = 8'hFD; pc_in = 16'h8000; irq = 1;
    step1(); idle(7); irq = 0;                     // R6 push at FD
    s_in = 8'hFA; rti = 1; step1(); idle(5);       // R8 normal return
    phase_tag = "R9"; s_in = 8'hFF; pc_in = 16'h2468;
    plp = 1; step1(); idle(3);                     // R9 pull wraps to 0x0100
    finish_run();
  end
endmodule